// File: doc/BRIEF.md
# Exception Prioritizer and Vector Generator

This block sits at the front of a processor core and decides, every cycle, whether an exception is entered and which one. Seven request lines come in: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction and software interrupt. The two interrupt lines are qualified by the mask bits of the current status word. The highest-priority surviving request wins.

For the winner, the block produces a registered entry record one clock later. The record holds the fixed vector address, the target processor mode, the return address for that mode's link register, a copy of the status word as it stood when the request was seen, and the status word the core must load on entry. The core uses this record to redirect fetch and to update its banked registers. Instruction execution, register banking and handler code lie outside this block.

The status word layout assumed here is: bits [4:0] mode, bit 5 compact-instruction-state flag (T), bit 6 fast-interrupt mask (F), bit 7 normal-interrupt mask (I). All higher bits are passed through untouched.

Top module: `exc_prioritizer`

## Requirements
- R1: While `rst` is high at a rising edge, the following outputs read zero after that edge: `exc_take`, `exc_vector`, `exc_mode`, `exc_link`, `exc_saved_sr` and `exc_new_sr`.
- R2: Among unmasked requests, the winner is chosen in this order, highest first: reset, data abort, fast interrupt, normal interrupt, prefetch abort, then undefined instruction and software interrupt. The last two are never raised together.
- R3: A normal-interrupt request is ignored while `cur_sr[7]` is 1. A fast-interrupt request is ignored while `cur_sr[6]` is 1. If nothing else is pending, `exc_take` stays 0.
- R4: The vector equals `VEC_BASE` plus a per-source offset: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C. Offset 0x14 is never issued.
- R5: The target mode is set per source. Reset and software interrupt use 5'h13 (supervisor). Both aborts use 5'h17. Undefined instruction uses 5'h1B. The normal interrupt uses 5'h12 and the fast interrupt uses 5'h11.
- R6: The new status word copies `cur_sr` above bit 7. It sets bits [4:0] to the target mode, clears bit 5 and sets bit 7. It sets bit 6 for reset and fast interrupt, and otherwise keeps bit 6 from `cur_sr`.
- R7: `exc_saved_sr` equals the `cur_sr` value present in the cycle the request was sampled.
- R8: `exc_link` is `cur_pc + 8` for data abort and `cur_pc + 4` for every other source.
- R9: Consider service of the normal interrupt (mode 5'h12, I=1, F=0). A fast-interrupt request there is taken. Consider service of the fast interrupt (I=1, F=1). A normal-interrupt request there is not taken.
- R10: Outputs appear exactly one clock after the requests are sampled. `exc_take` returns to 0 one clock after the requests are removed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_reset | input | 1 | Reset exception request |
| req_dabt | input | 1 | Data abort request |
| req_fiq | input | 1 | Fast interrupt request |
| req_irq | input | 1 | Normal interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_undef | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| cur_sr | input | DATA_W | Current status word |
| cur_pc | input | DATA_W | Address used to form the return address |
| exc_take | output | 1 | Exception entry this cycle |
| exc_vector | output | DATA_W | Vector address |
| exc_mode | output | 5 | Target mode encoding |
| exc_link | output | DATA_W | Return address for the target link register |
| exc_saved_sr | output | DATA_W | Saved copy of the status word |
| exc_new_sr | output | DATA_W | Status word to load on entry |

## Verification
Priority selection and interrupt masking act in the same cycle. An interrupt request can lose either to its mask bit or to a higher source, and the outcome depends on both. The bench drives every legal combination of the seven requests against all four settings of the two mask bits. For each case it computes the expected winner, vector, mode, link and status words arithmetically, then compares them one clock later. Directed cases then place the core in each interrupt's service state, to show that fast interrupts preempt normal ones and never the reverse.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int NUM_SRC = 7;

    // status word bit positions
    localparam int SR_T = 5;
    localparam int SR_F = 6;
    localparam int SR_I = 7;

    // index equals priority rank (0 = highest)
    typedef enum logic [2:0] {
        SRC_RESET = 3'd0,
        SRC_DABT  = 3'd1,
        SRC_FIQ   = 3'd2,
        SRC_IRQ   = 3'd3,
        SRC_PABT  = 3'd4,
        SRC_UNDEF = 3'd5,
        SRC_SWI   = 3'd6
    } exc_src_e;

    typedef enum logic [4:0] {
        MODE_USR = 5'h10,
        MODE_FIQ = 5'h11,
        MODE_IRQ = 5'h12,
        MODE_SVC = 5'h13,
        MODE_ABT = 5'h17,
        MODE_UND = 5'h1B,
        MODE_SYS = 5'h1F
    } cpu_mode_e;

    typedef struct packed {
        logic     valid;
        exc_src_e src;
    } grant_t;

    function automatic logic [7:0] vec_offset(exc_src_e s);
        case (s)
            SRC_RESET: return 8'h00;
            SRC_UNDEF: return 8'h04;
            SRC_SWI:   return 8'h08;
            SRC_PABT:  return 8'h0C;
            SRC_DABT:  return 8'h10;
            SRC_IRQ:   return 8'h18;
            SRC_FIQ:   return 8'h1C;
            default:   return 8'h00;
        endcase
    endfunction

    function automatic cpu_mode_e target_mode(exc_src_e s);
        case (s)
            SRC_FIQ:            return MODE_FIQ;
            SRC_IRQ:            return MODE_IRQ;
            SRC_DABT, SRC_PABT: return MODE_ABT;
            SRC_UNDEF:          return MODE_UND;
            default:            return MODE_SVC;
        endcase
    endfunction

    function automatic logic [3:0] link_offset(exc_src_e s);
        return (s == SRC_DABT) ? 4'd8 : 4'd4;
    endfunction

    function automatic logic masks_fast(exc_src_e s);
        return (s == SRC_RESET) || (s == SRC_FIQ);
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic [NUM_SRC-1:0] req_raw,
    input  logic               mask_i,
    input  logic               mask_f,
    output grant_t             grant
);
    logic [NUM_SRC-1:0] req_eff;

    always_comb begin
        req_eff          = req_raw;
        req_eff[SRC_IRQ] = req_raw[SRC_IRQ] & ~mask_i;
        req_eff[SRC_FIQ] = req_raw[SRC_FIQ] & ~mask_f;
    end

    // scan from lowest rank upward so the highest rank assigns last
    always_comb begin
        grant.valid = 1'b0;
        grant.src   = SRC_RESET;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req_eff[i]) begin
                grant.valid = 1'b1;
                grant.src   = exc_src_e'(3'(i));
            end
        end
    end
endmodule

// File: rtl/exc_entry_gen.sv
module exc_entry_gen
    import exc_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter logic [31:0] VEC_BASE = 32'h0
) (
    input  exc_src_e          src,
    input  logic [DATA_W-1:0] sr_in,
    input  logic [DATA_W-1:0] pc_in,
    output logic [DATA_W-1:0] vector,
    output logic [4:0]        mode,
    output logic [DATA_W-1:0] link,
    output logic [DATA_W-1:0] new_sr
);
    localparam logic [DATA_W-1:0] BASE = DATA_W'(VEC_BASE);

    always_comb begin
        vector = BASE + DATA_W'(vec_offset(src));
        mode   = target_mode(src);
        link   = pc_in + DATA_W'(link_offset(src));
        new_sr          = sr_in;
        new_sr[4:0]     = target_mode(src);
        new_sr[SR_T]    = 1'b0;
        new_sr[SR_I]    = 1'b1;
        new_sr[SR_F]    = sr_in[SR_F] | masks_fast(src);
    end
endmodule

// File: rtl/exc_prioritizer.sv
module exc_prioritizer
    import exc_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter logic [31:0] VEC_BASE = 32'h0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_reset,
    input  logic              req_dabt,
    input  logic              req_fiq,
    input  logic              req_irq,
    input  logic              req_pabt,
    input  logic              req_undef,
    input  logic              req_swi,
    input  logic [DATA_W-1:0] cur_sr,
    input  logic [DATA_W-1:0] cur_pc,
    output logic              exc_take,
    output logic [DATA_W-1:0] exc_vector,
    output logic [4:0]        exc_mode,
    output logic [DATA_W-1:0] exc_link,
    output logic [DATA_W-1:0] exc_saved_sr,
    output logic [DATA_W-1:0] exc_new_sr
);
    logic [NUM_SRC-1:0] req_vec;
    grant_t             grant;
    logic [DATA_W-1:0]  nxt_vector, nxt_link, nxt_new_sr;
    logic [4:0]         nxt_mode;

    always_comb begin
        req_vec            = '0;
        req_vec[SRC_RESET] = req_reset;
        req_vec[SRC_DABT]  = req_dabt;
        req_vec[SRC_FIQ]   = req_fiq;
        req_vec[SRC_IRQ]   = req_irq;
        req_vec[SRC_PABT]  = req_pabt;
        req_vec[SRC_UNDEF] = req_undef;
        req_vec[SRC_SWI]   = req_swi;
    end

    exc_arbiter u_arb (
        .req_raw (req_vec),
        .mask_i  (cur_sr[SR_I]),
        .mask_f  (cur_sr[SR_F]),
        .grant   (grant)
    );

    exc_entry_gen #(
        .DATA_W   (DATA_W),
        .VEC_BASE (VEC_BASE)
    ) u_gen (
        .src    (grant.src),
        .sr_in  (cur_sr),
        .pc_in  (cur_pc),
        .vector (nxt_vector),
        .mode   (nxt_mode),
        .link   (nxt_link),
        .new_sr (nxt_new_sr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            exc_take     <= 1'b0;
            exc_vector   <= '0;
            exc_mode     <= '0;
            exc_link     <= '0;
            exc_saved_sr <= '0;
            exc_new_sr   <= '0;
        end else begin
            exc_take     <= grant.valid;
            exc_vector   <= nxt_vector;
            exc_mode     <= nxt_mode;
            exc_link     <= nxt_link;
            exc_saved_sr <= cur_sr;
            exc_new_sr   <= nxt_new_sr;
        end
    end

    localparam logic [DATA_W-1:0] RSVD_VEC = DATA_W'(VEC_BASE) + DATA_W'(8'h14);

    AST_NO_RSVD_VECTOR: assert property (@(posedge clk) disable iff (rst)
        exc_take |-> exc_vector != RSVD_VEC);  // R4
    AST_RESET_WINS: assert property (@(posedge clk) disable iff (rst)
        (req_reset && !rst) |=> exc_take && exc_vector == DATA_W'(VEC_BASE));  // R2
    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (rst)
        (exc_take && exc_mode == MODE_IRQ) |-> !$past(cur_sr[SR_I]));  // R3
    AST_FIQ_MASK: assert property (@(posedge clk) disable iff (rst)
        (exc_take && exc_mode == MODE_FIQ) |-> !$past(cur_sr[SR_F]));  // R3
    AST_SAVED_SR: assert property (@(posedge clk) disable iff (rst)
        exc_take |-> exc_saved_sr == $past(cur_sr));  // R7
    AST_ENTRY_BITS: assert property (@(posedge clk) disable iff (rst)
        exc_take |-> (exc_new_sr[SR_I] && !exc_new_sr[SR_T]
                      && exc_new_sr[4:0] == exc_mode));  // R6
endmodule

// File: tb/exc_prioritizer_tb.sv
module exc_prioritizer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  req = '0;   // bit0 reset .. bit6 swi
    logic [31:0] cur_sr = '0;
    logic [31:0] cur_pc = '0;
    logic        exc_take;
    logic [31:0] exc_vector, exc_link, exc_saved_sr, exc_new_sr;
    logic [4:0]  exc_mode;
    int          errors = 0;
    int          checks = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    exc_prioritizer u_dut (
        .clk (clk), .rst (rst),
        .req_reset (req[0]), .req_dabt (req[1]), .req_fiq (req[2]),
        .req_irq (req[3]), .req_pabt (req[4]), .req_undef (req[5]),
        .req_swi (req[6]),
        .cur_sr (cur_sr), .cur_pc (cur_pc),
        .exc_take (exc_take), .exc_vector (exc_vector), .exc_mode (exc_mode),
        .exc_link (exc_link), .exc_saved_sr (exc_saved_sr),
        .exc_new_sr (exc_new_sr)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (req=%b sr=%h)", tag, act, exp, req, cur_sr);
        end
    endtask

    // apply one stimulus, evaluate one clock later
    task automatic run_case(logic [6:0] r, logic [31:0] sr, logic [31:0] pc);
        int   win;
        logic [31:0] ev, el, ens;
        logic [4:0]  em;
        logic setf;
        @(negedge clk);
        req = r; cur_sr = sr; cur_pc = pc;
        win = -1;
        if (r[0]) win = 0;
        else if (r[1]) win = 1;
        else if (r[2] && !sr[6]) win = 2;
        else if (r[3] && !sr[7]) win = 3;
        else if (r[4]) win = 4;
        else if (r[5]) win = 5;
        else if (r[6]) win = 6;
        case (win)
            0: begin ev = 32'h00; em = 5'h13; end
            1: begin ev = 32'h10; em = 5'h17; end
            2: begin ev = 32'h1C; em = 5'h11; end
            3: begin ev = 32'h18; em = 5'h12; end
            4: begin ev = 32'h0C; em = 5'h17; end
            5: begin ev = 32'h04; em = 5'h1B; end
            default: begin ev = 32'h08; em = 5'h13; end
        endcase
        el   = pc + ((win == 1) ? 32'd8 : 32'd4);
        setf = (win == 0) || (win == 2);
        ens  = {sr[31:8], 1'b1, sr[6] | setf, 1'b0, em};
        @(posedge clk);
        @(negedge clk);
        check("R2/R3/R10 take", {31'b0, exc_take}, {31'b0, win >= 0});
        if (win >= 0) begin
            check("R2/R4 vector", exc_vector, ev);
            check("R5 mode", {27'b0, exc_mode}, {27'b0, em});
            check("R8 link", exc_link, el);
            check("R7 saved", exc_saved_sr, sr);
            check("R6 new_sr", exc_new_sr, ens);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 take", {31'b0, exc_take}, 32'h0);
        check("R1 vector", exc_vector, 32'h0);
        check("R1 mode", {27'b0, exc_mode}, 32'h0);
        check("R1 link", exc_link, 32'h0);
        check("R1 saved", exc_saved_sr, 32'h0);
        check("R1 new_sr", exc_new_sr, 32'h0);
        rst = 1'b0;
        // exhaustive sweep: every legal request set against every mask pair
        for (int r = 0; r < 128; r++) begin
            for (int m = 0; m < 4; m++) begin
                logic [31:0] sr;
                if (r[5] && r[6]) continue;
                sr = {24'(r * 37 + m * 11 + 24'h5A0000), m[1], m[0], 1'b1, 5'h10};
                run_case(7'(r), sr, 32'h4000_0000 + 32'(r * 64 + m * 4));
            end
        end
        // R9: fast interrupt preempts normal-interrupt service
        run_case(7'b0001100, {24'h0, 1'b1, 1'b0, 1'b0, 5'h12}, 32'h0000_2000);
        check("R9 fiq over irq service", {27'b0, exc_mode}, 32'h11);
        // R9: normal interrupt cannot preempt fast-interrupt service
        run_case(7'b0001000, {24'h0, 1'b1, 1'b1, 1'b0, 5'h11}, 32'h0000_3000);
        check("R9 irq blocked in fiq service", {31'b0, exc_take}, 32'h0);
        // R10: take drops one clock after requests are removed
        run_case(7'b0010000, 32'h0000_0010, 32'h100);
        run_case(7'b0000000, 32'h0000_0010, 32'h100);
        check("R10 idle", {31'b0, exc_take}, 32'h0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule